// File: doc/BRIEF.md
# DRAM page-mode burst controller

This block controls one DRAM area that sits on a shared external bus. A host presents a request with an address, a write flag, write data and a space-select bit. When the space-select bit marks the DRAM area, the controller takes the request. It splits the address into a row part and a column part and puts them on one multiplexed address bus. It drives the active-low RAS, CAS and write strobes. It also keeps the DRAM page open, so that a run of accesses to the same row needs only column cycles.

Opening a closed row takes four states. The first is a precharge state with RAS high. The second strobes the row. The last two form a column pair: the column address goes out in the first, and CAS falls in the second, which is also where data moves. Later accesses to the same row repeat only the column pair. What happens when the bus is not serving the DRAM depends on a mode input. In the held-page mode, RAS stays low while the bus is idle or serves another space, and the next access to the same row goes straight to the column pair. In the release mode, RAS rises as soon as no DRAM access follows.

A refresh request input starts a CAS-before-RAS refresh. It takes priority over a pending access and always closes the open page.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is asserted and right after it ends, RAS, CAS and WE are high (inactive), reqAck and rdValid are 0 and refAck is 0.
- R2: A DRAM access to a row that is not open takes four cycles after acceptance: precharge (RAS high), row strobe (RAS falls), column cycle 1 and column cycle 2 (CAS falls). RAS is always low in the cycle before CAS falls. Read data appears on rdData with rdValid high 5 cycles after the cycle in which reqAck was 1.
- R3: A DRAM access that hits the open row and is presented at a column-2 boundary is accepted 2 cycles after the previous acceptance. It issues only the column pair, with no new RAS fall, and its read data comes 3 cycles after acceptance.
- R4: For a write, WE is low in both column cycles and only while RAS is low, and ramDout carries the write data. A later read of the same address returns that data.
- R5: With rasDownMode = 1, RAS stays low while no DRAM access follows (idle or other-space cycles). A later access to the same row is accepted in that idle cycle, raises no new RAS fall and returns data 3 cycles after acceptance.
- R6: With rasDownMode = 0, RAS is high in the cycle after column cycle 2 when no DRAM access is presented at that boundary. The next access then opens its row again from precharge, with latency 5.
- R7: A row miss while RAS is low raises RAS for exactly one precharge cycle. RAS then falls again with the new row on the address bus, and latency is 5.
- R8: A refresh drives CAS low one cycle before RAS. Both then stay low for one cycle, both rise, and refAck is 1 in the following precharge cycle. refAck comes 3 cycles after refReq is raised from a closed page, or 4 cycles if RAS was being held low. After a refresh the open row is forgotten, so the next access has latency 5.
- R9: When refReq and a DRAM request are present at the same access boundary, the refresh runs first. reqAck stays 0 until the refresh has completed.
- R10: A request with reqDram = 0 is never acknowledged and causes no CAS activity.
- R11: The row is address bits [ROW_W+COL_W-1:COL_W], shown on ramAddr in the precharge and row-strobe cycles. The column is address bits [COL_W-1:0], shown on ramAddr in both column cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rasDownMode | input | 1 | 1: hold RAS low between DRAM accesses; 0: release it |
| reqValid | input | 1 | Host request present |
| reqDram | input | 1 | Request targets the DRAM area (0: another space) |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ROW_W+COL_W | Request address, row in upper bits |
| reqWdata | input | DATA_W | Write data |
| reqAck | output | 1 | Request accepted in this cycle |
| rdValid | output | 1 | Read data valid pulse |
| rdData | output | DATA_W | Read data |
| refReq | input | 1 | Refresh request, held until refAck |
| refAck | output | 1 | Refresh completed |
| ramAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ramRasN | output | 1 | Row strobe, active low |
| ramCasN | output | 1 | Column strobe, active low |
| ramWeN | output | 1 | Write enable, active low |
| ramDout | output | DATA_W | Data driven to the DRAM |
| ramDoutEn | output | 1 | Drive enable for ramDout |
| ramDin | input | DATA_W | Data returned by the DRAM |

## Verification
Some rules are checked by assertions on every cycle: the strobe ordering rules, namely a column CAS fall only after RAS has been low, CAS before RAS in refresh, WE only under RAS, and both strobes released when refAck is given. The same goes for refresh winning over a pending access, other-space requests never being acknowledged, and the page closing in release mode. Other behaviours need the bench's scenarios, because they depend on history. These are the latencies of hits and misses, RAS staying low across other-space cycles in held-page mode, the precharge cycle before a new row is strobed while RAS is held, and the page being forgotten after a refresh. The bench also uses a small DRAM model to confirm the row/column split, through full write and read sweeps in both modes.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW,
    ST_COL1,
    ST_COL2,
    ST_RF_PRE,
    ST_RF_CAS,
    ST_RF_BOTH,
    ST_RF_REC
  } dramState_e;

  // Strobes for the next cycle, registered into pins by the datapath.
  typedef struct packed {
    logic rasOn;
    logic casOn;
    logic weOn;
    logic selCol;
    logic driveData;
    logic latchReq;
    logic captureRead;
  } dramStrobe_t;

endpackage

// File: rtl/dram_page_fsm.sv
module dram_page_fsm
  import dram_page_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rasDownMode,
  input  logic        reqValid,
  input  logic        reqDram,
  input  logic        reqWrite,
  input  logic        rowHit,
  input  logic        refReq,
  output logic        reqAck,
  output logic        refAck,
  output dramStrobe_t strb
);

  dramState_e state, nextState;
  logic       rowOpen, rowOpenNext;
  logic       curWrite, writeNext;
  logic       accept;
  logic       boundary;

  assign boundary = (state == ST_IDLE) || (state == ST_COL2);

  always_comb begin
    nextState   = state;
    rowOpenNext = rowOpen;
    writeNext   = curWrite;
    accept      = 1'b0;
    case (state)
      ST_IDLE, ST_COL2: begin
        if (refReq) begin
          nextState   = rowOpen ? ST_RF_PRE : ST_RF_CAS;
          rowOpenNext = 1'b0;
        end else if (reqValid && reqDram) begin
          accept    = 1'b1;
          writeNext = reqWrite;
          if (rowOpen && rowHit) begin
            nextState = ST_COL1;
          end else begin
            nextState   = ST_PRE;
            rowOpenNext = 1'b0;
          end
        end else begin
          nextState   = ST_IDLE;
          rowOpenNext = rowOpen && rasDownMode;
        end
      end
      ST_PRE:     nextState = ST_ROW;
      ST_ROW: begin
        nextState   = ST_COL1;
        rowOpenNext = 1'b1;
      end
      ST_COL1:    nextState = ST_COL2;
      ST_RF_PRE:  nextState = ST_RF_CAS;
      ST_RF_CAS:  nextState = ST_RF_BOTH;
      ST_RF_BOTH: nextState = ST_RF_REC;
      ST_RF_REC:  nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.rasOn = (nextState == ST_ROW) || (nextState == ST_COL1) ||
                 (nextState == ST_COL2) || (nextState == ST_RF_BOTH) ||
                 ((nextState == ST_IDLE) && rowOpenNext);
    strb.casOn = (nextState == ST_COL2) || (nextState == ST_RF_CAS) ||
                 (nextState == ST_RF_BOTH);
    strb.selCol      = (nextState == ST_COL1) || (nextState == ST_COL2);
    strb.weOn        = writeNext && strb.selCol;
    strb.driveData   = writeNext && strb.selCol;
    strb.latchReq    = accept;
    strb.captureRead = (state == ST_COL2) && !curWrite;
  end

  assign reqAck = accept;
  assign refAck = (state == ST_RF_REC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rowOpen  <= 1'b0;
      curWrite <= 1'b0;
    end else begin
      state    <= nextState;
      rowOpen  <= rowOpenNext;
      curWrite <= writeNext;
    end
  end

  AST_ACK_DRAM_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (reqValid && reqDram)); // R10

  AST_REF_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && boundary) |-> !reqAck); // R9

  AST_UP_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && ($past(state) == ST_COL2) && !$past(rasDownMode)) |-> !rowOpen); // R6

endmodule

// File: rtl/dram_page_datapath.sv
module dram_page_datapath
  import dram_page_pkg::*;
#(
  parameter  int ROW_W  = 4,
  parameter  int COL_W  = 4,
  parameter  int DATA_W = 8,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dramStrobe_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramDin,
  output logic              rowHit,
  output logic [MUX_W-1:0]  ramAddr,
  output logic              ramRasN,
  output logic              ramCasN,
  output logic              ramWeN,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramDoutEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] curAddr, srcAddr;
  logic [DATA_W-1:0] curWdata, srcData;
  logic [MUX_W-1:0]  rowBus, colBus;

  assign srcAddr = strb.latchReq ? reqAddr  : curAddr;
  assign srcData = strb.latchReq ? reqWdata : curWdata;
  assign rowHit  = (reqAddr[ADDR_W-1:COL_W] == curAddr[ADDR_W-1:COL_W]);

  generate
    if (ROW_W == MUX_W) begin : gRowFull
      assign rowBus = srcAddr[ADDR_W-1:COL_W];
    end else begin : gRowPad
      assign rowBus = {{(MUX_W-ROW_W){1'b0}}, srcAddr[ADDR_W-1:COL_W]};
    end
    if (COL_W == MUX_W) begin : gColFull
      assign colBus = srcAddr[COL_W-1:0];
    end else begin : gColPad
      assign colBus = {{(MUX_W-COL_W){1'b0}}, srcAddr[COL_W-1:0]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      curWdata  <= '0;
      ramAddr   <= '0;
      ramRasN   <= 1'b1;
      ramCasN   <= 1'b1;
      ramWeN    <= 1'b1;
      ramDout   <= '0;
      ramDoutEn <= 1'b0;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      if (strb.latchReq) begin
        curAddr  <= reqAddr;
        curWdata <= reqWdata;
      end
      ramAddr   <= strb.selCol ? colBus : rowBus;
      ramRasN   <= ~strb.rasOn;
      ramCasN   <= ~strb.casOn;
      ramWeN    <= ~strb.weOn;
      ramDout   <= srcData;
      ramDoutEn <= strb.driveData;
      rdValid   <= strb.captureRead;
      if (strb.captureRead) rdData <= ramDin;
    end
  end

  AST_CAS_ROW_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ramCasN) && !ramRasN) |-> $past(!ramRasN)); // R2

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ramRasN) && !ramCasN) |-> $past(!ramCasN)); // R8

  AST_CBR_RAS_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (!ramCasN && ramRasN) |=> !ramRasN); // R8

  AST_WE_IN_ROW: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> (!ramRasN && ramDoutEn)); // R4

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_page_pkg::*;
#(
  parameter  int ROW_W  = 4,
  parameter  int COL_W  = 4,
  parameter  int DATA_W = 8,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasDownMode,
  input  logic              reqValid,
  input  logic              reqDram,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAck,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  input  logic              refReq,
  output logic              refAck,
  output logic [MUX_W-1:0]  ramAddr,
  output logic              ramRasN,
  output logic              ramCasN,
  output logic              ramWeN,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramDoutEn,
  input  logic [DATA_W-1:0] ramDin
);

  dramStrobe_t strb;
  logic        rowHit;

  dram_page_fsm fsm_i (
    .clk        (clk),
    .rstN       (rstN),
    .rasDownMode(rasDownMode),
    .reqValid   (reqValid),
    .reqDram    (reqDram),
    .reqWrite   (reqWrite),
    .rowHit     (rowHit),
    .refReq     (refReq),
    .reqAck     (reqAck),
    .refAck     (refAck),
    .strb       (strb)
  );

  dram_page_datapath #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .ramDin   (ramDin),
    .rowHit   (rowHit),
    .ramAddr  (ramAddr),
    .ramRasN  (ramRasN),
    .ramCasN  (ramCasN),
    .ramWeN   (ramWeN),
    .ramDout  (ramDout),
    .ramDoutEn(ramDoutEn),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  AST_REF_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    refAck |-> (ramRasN && ramCasN)); // R8

endmodule

// File: tb/dram_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_page_ctrl_tb_top;

  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W  = 4;
  localparam int MEM_N  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rasDownMode = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqDram = 1'b0;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              reqAck;
  logic              rdValid;
  logic [DATA_W-1:0] rdData;
  logic              refReq = 1'b0;
  logic              refAck;
  logic [MUX_W-1:0]  ramAddr;
  logic              ramRasN, ramCasN, ramWeN, ramDoutEn;
  logic [DATA_W-1:0] ramDout, ramDin;

  always #4 clk = ~clk;

  dram_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .rasDownMode(rasDownMode),
    .reqValid(reqValid), .reqDram(reqDram), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck),
    .rdValid(rdValid), .rdData(rdData), .refReq(refReq), .refAck(refAck),
    .ramAddr(ramAddr), .ramRasN(ramRasN), .ramCasN(ramCasN), .ramWeN(ramWeN),
    .ramDout(ramDout), .ramDoutEn(ramDoutEn), .ramDin(ramDin)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Simple DRAM model driven only by the pins
  logic [DATA_W-1:0] dmem [MEM_N];
  logic [ROW_W-1:0]  mRow = '0;
  logic              mPrevRasN = 1'b1;
  logic              mPrevCasN = 1'b1;
  int                actCnt = 0;
  int                cbrCnt = 0;

  assign ramDin = dmem[{mRow, ramAddr[COL_W-1:0]}];

  always @(negedge clk) begin
    if (mPrevRasN && !ramRasN) begin
      if (!ramCasN) cbrCnt++;
      else begin
        actCnt++;
        mRow = ramAddr[ROW_W-1:0];
      end
    end
    if (mPrevCasN && !ramCasN && !ramRasN && !ramWeN)
      dmem[{mRow, ramAddr[COL_W-1:0]}] = ramDout;
    mPrevRasN = ramRasN;
    mPrevCasN = ramCasN;
  end

  // Expected reads
  logic [DATA_W-1:0] shadow [MEM_N];
  logic [DATA_W-1:0] expData [$];
  int                expLat [$];
  int                expCyc [$];
  string             expTag [$];
  int lastAckCyc = 0;
  int prevAckCyc = 0;

  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expData.size() == 0) chk(1'b0, "R2 unexpected read data", 1, 0);
      else begin
        logic [DATA_W-1:0] d;
        int l, a;
        string t;
        d = expData.pop_front();
        l = expLat.pop_front();
        a = expCyc.pop_front();
        t = expTag.pop_front();
        chk(rdData == d, {t, " data"}, int'(rdData), int'(d));
        chk((cyc - a) == l, {t, " latency"}, cyc - a, l);
      end
    end
  end

  task automatic doReq(input bit wr, input int addr, input int data, input int lat, input string tag);
    reqValid = 1'b1;
    reqDram  = 1'b1;
    reqWrite = wr;
    reqAddr  = addr[ADDR_W-1:0];
    reqWdata = data[DATA_W-1:0];
    #1;
    while (!reqAck) begin
      @(negedge clk); #1;
    end
    prevAckCyc = lastAckCyc;
    lastAckCyc = cyc;
    if (wr) shadow[addr] = data[DATA_W-1:0];
    else begin
      expData.push_back(shadow[addr]);
      expLat.push_back(lat);
      expCyc.push_back(cyc);
      expTag.push_back(tag);
    end
    @(negedge clk); #1;
  endtask

  task automatic setIdle();
    reqValid = 1'b0;
    reqDram  = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic drain();
    setIdle();
    while (expData.size() != 0) begin
      @(negedge clk); #1;
    end
  endtask

  function automatic int patt(input int a, input int seed);
    return (a * 37 + seed) & 255;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a0, c0, start;
    for (int i = 0; i < MEM_N; i++) begin
      dmem[i] = '0;
      shadow[i] = '0;
    end
    // R1 reset state
    @(negedge clk); #1;
    chk(ramRasN && ramCasN && ramWeN, "R1 strobes in reset", {ramRasN, ramCasN, ramWeN}, 7);
    chk(!rdValid && !reqAck && !refAck, "R1 outputs in reset", {rdValid, reqAck, refAck}, 0);
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(2);
    chk(ramRasN && ramCasN && ramWeN && !rdValid, "R1 after reset", {ramRasN, ramCasN, ramWeN, rdValid}, 14);

    // Release mode: full write sweep, row-major (R3, R4, R11)
    rasDownMode = 1'b0;
    a0 = actCnt;
    for (int a = 0; a < MEM_N; a++) begin
      doReq(1'b1, a, patt(a, 11), 0, "R4 write");
      if (a == 1) chk(lastAckCyc - prevAckCyc == 4, "R2 gap after miss", lastAckCyc - prevAckCyc, 4);
      if (a == 2) chk(lastAckCyc - prevAckCyc == 2, "R3 hit gap", lastAckCyc - prevAckCyc, 2);
    end
    drain();
    waitCyc(2);
    chk(actCnt - a0 == 16, "R3 one activation per row in sweep", actCnt - a0, 16);
    chk(ramRasN == 1'b1, "R6 RAS released when idle", ramRasN, 1);

    // Held mode: column-major read sweep, every access a row miss (R7, R11, R4)
    rasDownMode = 1'b1;
    a0 = actCnt;
    for (int c = 0; c < (1 << COL_W); c++)
      for (int r = 0; r < (1 << ROW_W); r++)
        doReq(1'b0, (r << COL_W) | c, 0, 5, "R11 column-major readback");
    drain();
    chk(actCnt - a0 == MEM_N, "R7 activation per miss", actCnt - a0, MEM_N);
    chk(ramRasN == 1'b0, "R5 RAS held after sweep", ramRasN, 0);

    // Held mode across other-space cycles (R5, R10)
    a0 = actCnt;
    doReq(1'b0, 8'h31, 0, 5, "R7 miss from held row");
    reqDram = 1'b0;
    reqValid = 1'b1;
    while (expData.size() != 0) begin
      @(negedge clk); #1;
    end
    for (int i = 0; i < 4; i++) begin
      chk(ramRasN == 1'b0, "R5 RAS low during other space", ramRasN, 0);
      chk(ramCasN == 1'b1 && !reqAck, "R10 other space ignored", {ramCasN, reqAck}, 2);
      waitCyc(1);
    end
    doReq(1'b0, 8'h32, 0, 3, "R5 resume hit");
    drain();
    chk(actCnt - a0 == 1, "R5 no new activation on resume", actCnt - a0, 1);

    // Miss while RAS held low (R7, R11)
    a0 = actCnt;
    doReq(1'b0, 8'h52, 0, 5, "R7 miss latency");
    chk(ramRasN == 1'b1, "R7 precharge cycle", ramRasN, 1);
    waitCyc(1);
    chk(ramRasN == 1'b0, "R7 RAS falls again", ramRasN, 0);
    chk(ramAddr == 4'h5, "R11 row on address bus", int'(ramAddr), 5);
    drain();
    chk(actCnt - a0 == 1, "R7 one activation", actCnt - a0, 1);

    // Refresh while RAS held low (R8)
    c0 = cbrCnt;
    a0 = actCnt;
    refReq = 1'b1;
    start = cyc;
    #1;
    while (!refAck) begin
      @(negedge clk); #1;
    end
    chk(cyc - start == 4, "R8 refresh duration from held page", cyc - start, 4);
    chk(ramRasN && ramCasN, "R8 strobes released at refAck", {ramRasN, ramCasN}, 3);
    refReq = 1'b0;
    chk(cbrCnt - c0 == 1, "R8 one CAS-before-RAS", cbrCnt - c0, 1);
    doReq(1'b0, 8'h53, 0, 5, "R8 page forgotten after refresh");
    drain();
    chk(actCnt - a0 == 1, "R8 row reopened", actCnt - a0, 1);

    // Refresh priority over a pending access (R9)
    waitCyc(1);
    a0 = actCnt;
    refReq = 1'b1;
    reqValid = 1'b1;
    reqDram = 1'b1;
    reqWrite = 1'b0;
    reqAddr = 8'h54;
    start = cyc;
    #1;
    while (!refAck) begin
      chk(!reqAck, "R9 access held during refresh", reqAck, 0);
      @(negedge clk); #1;
    end
    chk(cyc - start == 4, "R9 refresh first", cyc - start, 4);
    refReq = 1'b0;
    doReq(1'b0, 8'h54, 0, 5, "R9 access after refresh");
    drain();
    chk(actCnt - a0 == 1, "R9 access opens row", actCnt - a0, 1);

    // Release mode page hits and write-then-read (R3, R4, R6)
    rasDownMode = 1'b0;
    waitCyc(2);
    a0 = actCnt;
    doReq(1'b0, 8'h70, 0, 5, "R2 closed row read");
    doReq(1'b0, 8'h71, 0, 3, "R3 hit read");
    doReq(1'b0, 8'h72, 0, 3, "R3 hit read 2");
    chk(lastAckCyc - prevAckCyc == 2, "R3 back-to-back gap", lastAckCyc - prevAckCyc, 2);
    doReq(1'b1, 8'h74, 8'hC3, 0, "R4 write in page");
    doReq(1'b0, 8'h74, 0, 3, "R4 read back in page");
    drain();
    chk(ramRasN == 1'b1, "R6 RAS high after last column", ramRasN, 1);
    chk(actCnt - a0 == 1, "R3 single activation for page", actCnt - a0, 1);
    reqValid = 1'b1;
    reqDram = 1'b0;
    waitCyc(2);
    chk(ramRasN == 1'b1 && !reqAck, "R10 other space in release mode", {ramRasN, reqAck}, 2);
    doReq(1'b0, 8'h73, 0, 5, "R6 same row reopened");
    drain();
    chk(actCnt - a0 == 2, "R6 reactivation", actCnt - a0, 2);

    // Refresh from a closed page (R8)
    waitCyc(1);
    c0 = cbrCnt;
    refReq = 1'b1;
    start = cyc;
    #1;
    while (!refAck) begin
      @(negedge clk); #1;
    end
    chk(cyc - start == 3, "R8 refresh duration from closed page", cyc - start, 3);
    refReq = 1'b0;
    waitCyc(2);
    chk(cbrCnt - c0 == 1, "R8 CAS-before-RAS count", cbrCnt - c0, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule